// File: doc/BRIEF.md
# Multi-Root Credit-Gated Packet Scheduler

This block sits on the transmit side of a link shared by several virtual hierarchies. A small set of request slots each present the head of a packet queue. The head carries a hierarchy number, a traffic class and a credit cost. Each hierarchy has its own table that turns a traffic class into a virtual link. The scheduler keeps two credit pools. One pool has a counter per virtual link. The other has a counter per (hierarchy, link) pair.

A packet is sent only when both of its counters can pay its cost. When it is sent, both counters are charged and a 32-bit label is emitted for it. The label holds the hierarchy number, the link number and that hierarchy's global key. The link layer places this label between the sequence number and the packet header. A retransmission reuses the stored label unchanged, so the scheduler never sees resent packets. Credit returns refill either pool. A packet that names a hierarchy outside the configured count is discarded and flagged. Hierarchy 0 is meant for management traffic. It is scheduled like any other hierarchy and is always inside the configured range.

Top module: `mr_tx_credit_sched`

## Requirements
- R1: A request is granted only when its link counter and its (hierarchy, link) counter are both at least its cost. Otherwise it waits with no output activity.
- R2: A grant subtracts the cost from both counters at the clock edge that makes the decision. A later request sees the reduced balances.
- R3: A credit return adds its amount to the addressed counter. The counter is clamped at VL_LIMIT for a link counter and at PAIR_LIMIT for a pair counter. A return and a charge to the same counter in one cycle are both applied.
- R4: Each hierarchy has its own traffic-class-to-link table, written through the map port. A write takes effect for requests decided after it.
- R5: One cycle after the decision edge, `tx_valid`, `tx_slot` and the matching bit of `ack` are high. `tx_prefix` then holds hierarchy number [31:24], link number [23:20], zero [19:16] and key [15:0].
- R6: The key field comes from a per-hierarchy key table written through the key port.
- R7: A request whose hierarchy is at or above min(`cfg_num_vh`, NUM_VH) is dropped. It raises `drop_err` and its `ack` bit for one cycle. It does not raise `tx_valid` and consumes no credits.
- R8: Among ready slots, service rotates round-robin, starting after the last slot serviced. After reset, slot 0 is searched first.
- R9: After reset, every counter is at its limit, every table entry maps to link 0, every key is 0, and `ack`, `tx_valid` and `drop_err` are low.
- R10: At most one `ack` bit is high per cycle. A slot whose `ack` is high is not considered at the next edge, so each queue head is serviced once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_num_vh | input | 9 | Number of hierarchies in use |
| map_we | input | 1 | Class-to-link table write strobe |
| map_vh | input | VHI_W | Hierarchy of the table write |
| map_tc | input | 3 | Traffic class of the table write |
| map_vl | input | VL_W | Link number written |
| key_we | input | 1 | Key table write strobe |
| key_vh | input | VHI_W | Hierarchy of the key write |
| key_val | input | KEY_W | Key value written |
| req_valid | input | NUM_SLOT | Slot holds a packet |
| req_vh | input | NUM_SLOT*8 | Hierarchy number per slot |
| req_tc | input | NUM_SLOT*3 | Traffic class per slot |
| req_cost | input | NUM_SLOT*COST_W | Credit cost per slot |
| ret_vl_en | input | 1 | Link credit return strobe |
| ret_vl_idx | input | VL_W | Link of the return |
| ret_vl_amt | input | COST_W | Amount returned |
| ret_pair_en | input | 1 | Pair credit return strobe |
| ret_pair_vh | input | VHI_W | Hierarchy of the return |
| ret_pair_vl | input | VL_W | Link of the return |
| ret_pair_amt | input | COST_W | Amount returned |
| ack | output | NUM_SLOT | One-hot: slot serviced (sent or dropped) |
| tx_valid | output | 1 | Packet granted |
| tx_slot | output | SLOT_W | Slot granted or dropped |
| tx_prefix | output | 16+KEY_W | Label for the granted packet |
| drop_err | output | 1 | Out-of-range hierarchy dropped |

## Verification
A wrong counter balance shows up as a grant in the wrong cycle. A stuck counter makes the affected request stall. A missed charge makes a later request go out while it should be waiting. So each pool is drained to just below a request's cost, the request is held for several cycles, and then exactly the missing credit is returned. A bad table entry or key shows up in the label of the very next grant from that hierarchy. A bad arbiter pointer shows up as a different slot order when three slots become ready in the same cycle.

// File: rtl/mr_sched_pkg.sv
package mr_sched_pkg;
  localparam int VH_FIELD_W = 8;
  localparam int VL_FIELD_W = 4;
  localparam int RSVD_W     = 4;
  localparam int TC_W       = 3;
  localparam int NUM_TC     = 1 << TC_W;
endpackage

// File: rtl/mr_credit_pool.sv
module mr_credit_pool #(
  parameter int N     = 4,
  parameter int LIMIT = 12,
  parameter int AMT_W = 4,
  localparam int IW   = $clog2(N),
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cons_en,
  input  logic [IW-1:0]    cons_idx,
  input  logic [AMT_W-1:0] cons_amt,
  input  logic             ret_en,
  input  logic [IW-1:0]    ret_idx,
  input  logic [AMT_W-1:0] ret_amt,
  output logic [CW-1:0]    cnt [N]
);
  logic [CW-1:0] cnt_n [N];

  for (genvar i = 0; i < N; i++) begin : g_ctr
    always_comb begin
      int nxt;
      nxt = int'(cnt[i]);
      if (cons_en && cons_idx == IW'(i)) nxt = nxt - int'(cons_amt);
      if (ret_en && ret_idx == IW'(i))   nxt = nxt + int'(ret_amt);
      if (nxt > LIMIT) nxt = LIMIT;
      cnt_n[i] = CW'(nxt);
    end

    always_ff @(posedge clk) begin
      if (rst) cnt[i] <= CW'(LIMIT);
      else     cnt[i] <= cnt_n[i];
    end

    p_cnt_limit_r3: assert property (@(posedge clk) disable iff (rst)
      int'(cnt[i]) <= LIMIT);
  end

  // The scheduler must never charge more than the balance it checked.
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    cons_en |-> (int'(cons_amt) <= int'(cnt[cons_idx])));
endmodule

// File: rtl/mr_vh_table.sv
module mr_vh_table
  import mr_sched_pkg::*;
#(
  parameter int NUM_VH = 4,
  parameter int VL_W   = 2,
  parameter int KEY_W  = 16,
  parameter int NRD    = 3,
  localparam int VHI_W = $clog2(NUM_VH),
  localparam int DEPTH = NUM_VH * NUM_TC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             map_we,
  input  logic [VHI_W-1:0] map_vh,
  input  logic [TC_W-1:0]  map_tc,
  input  logic [VL_W-1:0]  map_vl,
  input  logic             key_we,
  input  logic [VHI_W-1:0] key_vh,
  input  logic [KEY_W-1:0] key_val,
  input  logic [VHI_W-1:0] rd_vh [NRD],
  input  logic [TC_W-1:0]  rd_tc [NRD],
  output logic [VL_W-1:0]  rd_vl [NRD],
  output logic [KEY_W-1:0] rd_key [NRD]
);
  logic [VL_W-1:0]  map_mem [DEPTH];
  logic [KEY_W-1:0] key_mem [NUM_VH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)  map_mem[i] <= '0;
      for (int i = 0; i < NUM_VH; i++) key_mem[i] <= '0;
    end else begin
      if (map_we) map_mem[{map_vh, map_tc}] <= map_vl;
      if (key_we) key_mem[key_vh] <= key_val;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_vl[r]  = map_mem[{rd_vh[r], rd_tc[r]}];
    assign rd_key[r] = key_mem[rd_vh[r]];
  end
endmodule

// File: rtl/mr_rr_pick.sv
module mr_rr_pick #(
  parameter int N = 3,
  localparam int SW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [SW-1:0] last;
  logic [SW-1:0] win;

  always_comb begin
    logic found;
    int   idx;
    gnt   = '0;
    win   = last;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = (int'(last) + 1 + i) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = SW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last <= SW'(N - 1);
    else if (|gnt) last <= win;
  end
endmodule

// File: rtl/mr_tx_credit_sched.sv
module mr_tx_credit_sched
  import mr_sched_pkg::*;
#(
  parameter int NUM_SLOT   = 3,
  parameter int NUM_VH     = 4,
  parameter int NUM_VL     = 4,
  parameter int COST_W     = 4,
  parameter int KEY_W      = 16,
  parameter int VL_LIMIT   = 12,
  parameter int PAIR_LIMIT = 6,
  localparam int VHI_W  = $clog2(NUM_VH),
  localparam int VL_W   = $clog2(NUM_VL),
  localparam int SLOT_W = $clog2(NUM_SLOT),
  localparam int PFX_W  = VH_FIELD_W + VL_FIELD_W + RSVD_W + KEY_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [VH_FIELD_W:0]            cfg_num_vh,
  input  logic                           map_we,
  input  logic [VHI_W-1:0]               map_vh,
  input  logic [TC_W-1:0]                map_tc,
  input  logic [VL_W-1:0]                map_vl,
  input  logic                           key_we,
  input  logic [VHI_W-1:0]               key_vh,
  input  logic [KEY_W-1:0]               key_val,
  input  logic [NUM_SLOT-1:0]            req_valid,
  input  logic [NUM_SLOT*VH_FIELD_W-1:0] req_vh,
  input  logic [NUM_SLOT*TC_W-1:0]       req_tc,
  input  logic [NUM_SLOT*COST_W-1:0]     req_cost,
  input  logic                           ret_vl_en,
  input  logic [VL_W-1:0]                ret_vl_idx,
  input  logic [COST_W-1:0]              ret_vl_amt,
  input  logic                           ret_pair_en,
  input  logic [VHI_W-1:0]               ret_pair_vh,
  input  logic [VL_W-1:0]                ret_pair_vl,
  input  logic [COST_W-1:0]              ret_pair_amt,
  output logic [NUM_SLOT-1:0]            ack,
  output logic                           tx_valid,
  output logic [SLOT_W-1:0]              tx_slot,
  output logic [PFX_W-1:0]               tx_prefix,
  output logic                           drop_err
);
  localparam int NPAIR = NUM_VH * NUM_VL;
  localparam int PI_W  = $clog2(NPAIR);
  localparam int CWV   = $clog2(VL_LIMIT + 1);
  localparam int CWP   = $clog2(PAIR_LIMIT + 1);

  logic [VH_FIELD_W:0]     eff_num;
  logic [VH_FIELD_W-1:0]   s_vh   [NUM_SLOT];
  logic [VHI_W-1:0]        s_vhi  [NUM_SLOT];
  logic [TC_W-1:0]         s_tc   [NUM_SLOT];
  logic [COST_W-1:0]       s_cost [NUM_SLOT];
  logic [VL_W-1:0]         s_vl   [NUM_SLOT];
  logic [KEY_W-1:0]        s_key  [NUM_SLOT];
  logic [PI_W-1:0]         s_pair [NUM_SLOT];
  logic [NUM_SLOT-1:0]     vh_ok, cand, gnt;
  logic [CWV-1:0]          vl_cnt   [NUM_VL];
  logic [CWP-1:0]          pair_cnt [NPAIR];
  logic [SLOT_W-1:0]       sel;
  logic                    any_gnt, send;

  assign eff_num = (cfg_num_vh > (VH_FIELD_W+1)'(NUM_VH)) ? (VH_FIELD_W+1)'(NUM_VH) : cfg_num_vh;

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic vl_ok, pair_ok;
    assign s_vh[s]   = req_vh[s*VH_FIELD_W +: VH_FIELD_W];
    assign s_vhi[s]  = s_vh[s][VHI_W-1:0];
    assign s_tc[s]   = req_tc[s*TC_W +: TC_W];
    assign s_cost[s] = req_cost[s*COST_W +: COST_W];
    assign s_pair[s] = {s_vhi[s], s_vl[s]};
    assign vh_ok[s]  = {1'b0, s_vh[s]} < eff_num;
    assign vl_ok     = int'(s_cost[s]) <= int'(vl_cnt[s_vl[s]]);
    assign pair_ok   = int'(s_cost[s]) <= int'(pair_cnt[s_pair[s]]);
    assign cand[s]   = req_valid[s] && !ack[s] && (!vh_ok[s] || (vl_ok && pair_ok));
  end

  mr_vh_table #(.NUM_VH(NUM_VH), .VL_W(VL_W), .KEY_W(KEY_W), .NRD(NUM_SLOT)) u_table (
    .clk(clk), .rst(rst),
    .map_we(map_we), .map_vh(map_vh), .map_tc(map_tc), .map_vl(map_vl),
    .key_we(key_we), .key_vh(key_vh), .key_val(key_val),
    .rd_vh(s_vhi), .rd_tc(s_tc), .rd_vl(s_vl), .rd_key(s_key)
  );

  mr_rr_pick #(.N(NUM_SLOT)) u_arb (.clk(clk), .rst(rst), .req(cand), .gnt(gnt));

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SLOT; i++) if (gnt[i]) sel = SLOT_W'(i);
  end
  assign any_gnt = |gnt;
  assign send    = any_gnt && vh_ok[sel];

  mr_credit_pool #(.N(NUM_VL), .LIMIT(VL_LIMIT), .AMT_W(COST_W)) u_vl_pool (
    .clk(clk), .rst(rst),
    .cons_en(send), .cons_idx(s_vl[sel]), .cons_amt(s_cost[sel]),
    .ret_en(ret_vl_en), .ret_idx(ret_vl_idx), .ret_amt(ret_vl_amt),
    .cnt(vl_cnt)
  );

  mr_credit_pool #(.N(NPAIR), .LIMIT(PAIR_LIMIT), .AMT_W(COST_W)) u_pair_pool (
    .clk(clk), .rst(rst),
    .cons_en(send), .cons_idx(s_pair[sel]), .cons_amt(s_cost[sel]),
    .ret_en(ret_pair_en), .ret_idx({ret_pair_vh, ret_pair_vl}), .ret_amt(ret_pair_amt),
    .cnt(pair_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack       <= '0;
      tx_valid  <= 1'b0;
      drop_err  <= 1'b0;
      tx_slot   <= '0;
      tx_prefix <= '0;
    end else begin
      ack       <= gnt;
      tx_valid  <= send;
      drop_err  <= any_gnt && !vh_ok[sel];
      tx_slot   <= sel;
      tx_prefix <= {s_vh[sel], VL_FIELD_W'(s_vl[sel]), {RSVD_W{1'b0}}, s_key[sel]};
    end
  end

  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));
  p_no_repeat_r10: assert property (@(posedge clk) disable iff (rst)
    (ack != '0) |=> ((ack & $past(ack)) == '0));
  p_drop_no_tx_r7: assert property (@(posedge clk) disable iff (rst)
    drop_err |-> !tx_valid);
  p_event_has_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid || drop_err) == (ack != '0));
endmodule

// File: tb/mr_tx_credit_sched_tb.sv
`timescale 1ns/1ps
module mr_tx_credit_sched_tb;
  typedef struct packed { logic [7:0] vh; logic [2:0] tc; logic [3:0] cost; } req_t;
  typedef struct packed { logic drop; logic [1:0] slot; logic [31:0] pfx; } exp_t;

  logic clk = 0, rst = 1;
  logic [8:0] cfg_num_vh = 9'd3;
  logic map_we = 0, key_we = 0, ret_vl_en = 0, ret_pair_en = 0;
  logic [1:0] map_vh = 0, key_vh = 0, ret_pair_vh = 0;
  logic [2:0] map_tc = 0;
  logic [1:0] map_vl = 0, ret_vl_idx = 0, ret_pair_vl = 0;
  logic [15:0] key_val = 0;
  logic [3:0] ret_vl_amt = 0, ret_pair_amt = 0;
  logic [2:0] req_valid = 0;
  logic [23:0] req_vh = 0;
  logic [8:0] req_tc = 0;
  logic [11:0] req_cost = 0;
  logic [2:0] ack;
  logic tx_valid, drop_err;
  logic [1:0] tx_slot;
  logic [31:0] tx_prefix;

  int checks = 0, errors = 0;
  req_t sq0[$], sq1[$], sq2[$];
  exp_t exp_q[$];
  string tag_q[$];

  mr_tx_credit_sched u_dut (
    .clk(clk), .rst(rst), .cfg_num_vh(cfg_num_vh),
    .map_we(map_we), .map_vh(map_vh), .map_tc(map_tc), .map_vl(map_vl),
    .key_we(key_we), .key_vh(key_vh), .key_val(key_val),
    .req_valid(req_valid), .req_vh(req_vh), .req_tc(req_tc), .req_cost(req_cost),
    .ret_vl_en(ret_vl_en), .ret_vl_idx(ret_vl_idx), .ret_vl_amt(ret_vl_amt),
    .ret_pair_en(ret_pair_en), .ret_pair_vh(ret_pair_vh), .ret_pair_vl(ret_pair_vl),
    .ret_pair_amt(ret_pair_amt),
    .ack(ack), .tx_valid(tx_valid), .tx_slot(tx_slot), .tx_prefix(tx_prefix),
    .drop_err(drop_err)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pf(input int vh, input int vl, input logic [15:0] key);
    return {8'(vh), 4'(vl), 4'h0, key};
  endfunction

  // Driver side: slot heads advance when their ack is seen.
  always @(negedge clk) begin
    if (!rst) begin
      if (ack[0] && sq0.size() > 0) void'(sq0.pop_front());
      if (ack[1] && sq1.size() > 0) void'(sq1.pop_front());
      if (ack[2] && sq2.size() > 0) void'(sq2.pop_front());
    end
    req_valid[0] = sq0.size() > 0;
    req_valid[1] = sq1.size() > 0;
    req_valid[2] = sq2.size() > 0;
    if (sq0.size() > 0) begin req_vh[7:0]   = sq0[0].vh; req_tc[2:0] = sq0[0].tc; req_cost[3:0]  = sq0[0].cost; end
    if (sq1.size() > 0) begin req_vh[15:8]  = sq1[0].vh; req_tc[5:3] = sq1[0].tc; req_cost[7:4]  = sq1[0].cost; end
    if (sq2.size() > 0) begin req_vh[23:16] = sq2[0].vh; req_tc[8:6] = sq2[0].tc; req_cost[11:8] = sq2[0].cost; end
  end

  // Monitor side: every grant or drop is compared with the next expected item.
  always @(negedge clk) begin
    if (!rst && (tx_valid || drop_err)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R10", "unexpected service", {31'd0, drop_err, tx_slot, tx_prefix}, 64'd0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(drop_err == e.drop && tx_valid == !e.drop && tx_slot == e.slot &&
            ack == 3'(1 << e.slot) && (e.drop || tx_prefix == e.pfx), t, "service",
            {29'd0, ack, drop_err, tx_slot, tx_prefix},
            {29'd0, 3'(1 << e.slot), e.drop, e.slot, e.pfx});
      end
    end
  end

  task automatic push_req(input int s, input int vh, input int tc, input int cost);
    req_t r;
    r = '{vh: 8'(vh), tc: 3'(tc), cost: 4'(cost)};
    case (s)
      0: sq0.push_back(r);
      1: sq1.push_back(r);
      default: sq2.push_back(r);
    endcase
  endtask

  task automatic expect_tx(input int s, input logic [31:0] p, input string t);
    exp_q.push_back('{drop: 1'b0, slot: 2'(s), pfx: p});
    tag_q.push_back(t);
  endtask

  task automatic expect_drop(input int s, input string t);
    exp_q.push_back('{drop: 1'b1, slot: 2'(s), pfx: 32'd0});
    tag_q.push_back(t);
  endtask

  task automatic wait_drain(input string t);
    int n = 0;
    while ((exp_q.size() != 0 || sq0.size() != 0 || sq1.size() != 0 || sq2.size() != 0) && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (n >= 300) begin
      chk(0, t, "drain timeout", 64'(exp_q.size()), 64'd0);
      exp_q.delete(); tag_q.delete(); sq0.delete(); sq1.delete(); sq2.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic stall(input int n, input string t);
    repeat (n) begin
      @(negedge clk);
      chk(!tx_valid && !drop_err && ack == 3'd0, t, "stall expected",
          {62'd0, tx_valid, drop_err}, 64'd0);
    end
  endtask

  task automatic wr_map(input int vh, input int tc, input int vl);
    @(negedge clk);
    map_we = 1; map_vh = 2'(vh); map_tc = 3'(tc); map_vl = 2'(vl);
    @(negedge clk);
    map_we = 0;
  endtask

  task automatic wr_key(input int vh, input logic [15:0] k);
    @(negedge clk);
    key_we = 1; key_vh = 2'(vh); key_val = k;
    @(negedge clk);
    key_we = 0;
  endtask

  task automatic give_pair(input int vh, input int vl, input int amt);
    @(negedge clk);
    ret_pair_en = 1; ret_pair_vh = 2'(vh); ret_pair_vl = 2'(vl); ret_pair_amt = 4'(amt);
    @(negedge clk);
    ret_pair_en = 0;
  endtask

  task automatic give_vl(input int vl, input int amt);
    @(negedge clk);
    ret_vl_en = 1; ret_vl_idx = 2'(vl); ret_vl_amt = 4'(amt);
    @(negedge clk);
    ret_vl_en = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ack == 3'd0, "R9", "ack after reset", 64'(ack), 64'd0);
    chk(!tx_valid && !drop_err, "R9", "tx/drop after reset", {62'd0, tx_valid, drop_err}, 64'd0);

    wr_map(1, 0, 1); wr_map(1, 1, 2); wr_map(2, 0, 1);
    wr_key(0, 16'h0A0A); wr_key(1, 16'h1111); wr_key(2, 16'h2222);

    // R4 R5 R6: single grant with a per-hierarchy mapping and key
    expect_tx(0, pf(1, 1, 16'h1111), "R4");
    push_req(0, 1, 0, 2);
    wait_drain("R5");

    // R8: three slots become ready together; pointer is at slot 0, so order is 1, 2, 0.
    // Slot 0 uses VH0 class 5, never written: R9 default link 0.
    expect_tx(1, pf(2, 1, 16'h2222), "R8");
    expect_tx(2, pf(1, 2, 16'h1111), "R8");
    expect_tx(0, pf(0, 0, 16'h0A0A), "R9");
    push_req(0, 0, 5, 1); push_req(1, 2, 0, 1); push_req(2, 1, 1, 1);
    wait_drain("R8");

    // R2: pair (1,1) holds 4; cost 3 leaves 1. R1: cost 2 must wait.
    expect_tx(0, pf(1, 1, 16'h1111), "R2");
    push_req(0, 1, 0, 3);
    wait_drain("R2");
    push_req(0, 1, 0, 2);
    stall(6, "R1");
    expect_tx(0, pf(1, 1, 16'h1111), "R3");
    give_pair(1, 1, 1);
    wait_drain("R3");

    // R1: link 1 holds 4, pair (2,1) holds 5; cost 5 waits on the link pool.
    push_req(1, 2, 0, 5);
    stall(6, "R1");
    expect_tx(1, pf(2, 1, 16'h2222), "R3");
    give_vl(1, 1);
    wait_drain("R3");

    // R3: pair (1,2) holds 5; a return of 15 clamps to 6. Cost 6 goes, then cost 1 waits.
    give_pair(1, 2, 15);
    expect_tx(2, pf(1, 2, 16'h1111), "R3");
    push_req(2, 1, 1, 6);
    wait_drain("R3");
    push_req(2, 1, 1, 1);
    stall(5, "R3");
    expect_tx(2, pf(1, 2, 16'h1111), "R3");
    give_pair(1, 2, 1);
    wait_drain("R3");

    // R7: hierarchies 200 and 3 are out of range (count 3). Pointer at slot 2, so slot 0 first.
    expect_drop(0, "R7");
    expect_drop(2, "R7");
    push_req(0, 200, 0, 1); push_req(2, 3, 0, 1);
    wait_drain("R7");

    // R7: with count 4, VH3 cost 6 needs the full pair (3,0), so the drop consumed nothing.
    cfg_num_vh = 9'd4;
    expect_tx(2, pf(3, 0, 16'h0000), "R7");
    push_req(2, 3, 0, 6);
    wait_drain("R7");

    // R7: a count above the supported hierarchies is clamped; VH5 is dropped.
    cfg_num_vh = 9'd9;
    expect_drop(1, "R7");
    push_req(1, 5, 0, 1);
    wait_drain("R7");
    stall(3, "R10");

    finish_run();
  end
endmodule